// File: doc/BRIEF.md
# Compare-Based Watchdog Interval Timer

This block is a 7-bit watchdog counter that advances on a one-cycle strobe from an external interval prescaler. On each strobe it compares its count against a value that software has programmed. When a strobe arrives while the count equals that value, the period has expired. The counter then wraps to zero. The block either raises a one-cycle reset request or sets a sticky interrupt flag, depending on a mode input. With the mode input low, the block serves as a plain periodic 7-bit interval timer. The period is (compare value + 1) prescaler strobes.

Software reaches the block through one write-only 8-bit control register. The low seven bits hold the compare value. The top bit is a clear command: it zeroes the counter and then drops back to 0 by itself one cycle later. Firmware that is working correctly writes the clear bit again before each period runs out. The mode input comes from a clock-control register that sits outside this block and resets to 0, so the reset function is off after reset. A stop-mode input freezes the counter without losing its value.

Top module: `wdt_cmp_timer`

## Requirements
- R1: After reset, rst_req_o and irq_o are 0, the compare value is 127 and the clear bit is 0. With no register write, the first expiry happens on the 128th tick.
- R2: A control write loads bits 6..0 as the compare value. A write with bit 7 = 0 changes the compare value but leaves the current count untouched.
- R3: A control write with bit 7 = 1 forces the counter to 0. The clear bit then returns to 0 by itself after one cycle, and counting resumes on later ticks.
- R4: The counter advances only in cycles where tick_i is 1. Cycles without a tick leave the count unchanged.
- R5: Expiry happens on the (compare + 1)th tick counted from zero. The outputs update on the same clock edge that samples that tick.
- R6: With rst_mode_i = 1, an expiry drives rst_req_o to 1 for exactly one cycle and leaves irq_o unchanged.
- R7: With rst_mode_i = 0, an expiry sets irq_o. irq_o stays set until an irq_ack_i pulse. If an acknowledge and a new expiry fall in the same cycle, the flag stays set.
- R8: On expiry the counter wraps to 0, so expiries repeat every (compare + 1) ticks.
- R9: While stop_i is 1, ticks are ignored and the count is held. When stop_i returns to 0, counting continues from the held value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | One-cycle prescaler strobe |
| stop_i | input | 1 | Stop mode: freeze the counter |
| rst_mode_i | input | 1 | 1: expiry requests a reset; 0: expiry sets the interrupt flag |
| wr_en_i | input | 1 | Control register write strobe |
| wr_data_i | input | 8 | Control data: bit 7 = clear, bits 6..0 = compare value |
| irq_ack_i | input | 1 | Clears the interrupt flag |
| rst_req_o | output | 1 | Registered one-cycle reset request |
| irq_o | output | 1 | Sticky interrupt flag |

## Verification
A tick sampled at a clock edge shows up on rst_req_o or irq_o at that same edge, with no further delay. The bench drives every input at the falling edge and reads the outputs at the next falling edge, half a cycle after the edge that sampled the tick. The clear bit takes two edges to act: one edge registers the write, and the next edge zeroes the counter. For that reason the write task waits one extra cycle before any tick is driven. Each expiry check asserts no event after N-1 ticks and an event after N ticks, so the period is pinned to the exact tick.

// File: rtl/wdt_cmp_pkg.sv
package wdt_cmp_pkg;
  parameter int unsigned CMP_W = 7;
  localparam int unsigned REG_W = CMP_W + 1;
  localparam int unsigned CLR_BIT = CMP_W;
  typedef logic [CMP_W-1:0] cmp_t;
  localparam cmp_t CMP_RST = '1;
endpackage

// File: rtl/wdt_cmp_ctrl.sv
module wdt_cmp_ctrl
  import wdt_cmp_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [REG_W-1:0] wr_data_i,
  output cmp_t             cmp_o,
  output logic             clr_o
);
  cmp_t cmp_q;
  logic clr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cmp_q <= CMP_RST;
      clr_q <= 1'b0;
    end else begin
      if (wr_en_i) cmp_q <= wr_data_i[CMP_W-1:0];
      // clear bit lives one cycle only
      clr_q <= wr_en_i & wr_data_i[CLR_BIT];
    end
  end

  assign cmp_o = cmp_q;
  assign clr_o = clr_q;

  AST_CLR_SELF_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_q && !(wr_en_i && wr_data_i[CLR_BIT])) |=> !clr_q); // R3
  AST_CMP_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_en_i |=> $stable(cmp_q)); // R2
endmodule

// File: rtl/wdt_cmp_counter.sv
module wdt_cmp_counter
  import wdt_cmp_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic stop_i,
  input  logic clr_i,
  input  cmp_t cmp_i,
  output logic hit_o
);
  cmp_t cnt_q;
  logic adv, at_cmp;

  always_comb begin
    at_cmp = (cnt_q == cmp_i);
    adv    = tick_i & ~stop_i & ~clr_i;
    hit_o  = adv & at_cmp;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    cnt_q <= '0;
    else if (clr_i) cnt_q <= '0;
    else if (adv)   cnt_q <= at_cmp ? '0 : cnt_q + 1'b1;
  end

  AST_CLR_ZEROES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (cnt_q == '0)); // R3
  AST_STOP_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stop_i && !clr_i) |=> $stable(cnt_q)); // R9
  AST_IDLE_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tick_i && !clr_i) |=> $stable(cnt_q)); // R4
  AST_WRAP_ON_HIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit_o |=> (cnt_q == '0)); // R8
endmodule

// File: rtl/wdt_cmp_event.sv
module wdt_cmp_event (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic hit_i,
  input  logic mode_i,
  input  logic ack_i,
  output logic rst_req_o,
  output logic irq_o
);
  logic rst_q, irq_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rst_q <= 1'b0;
      irq_q <= 1'b0;
    end else begin
      rst_q <= hit_i & mode_i;
      // a new expiry wins over acknowledge
      if (hit_i && !mode_i) irq_q <= 1'b1;
      else if (ack_i)       irq_q <= 1'b0;
    end
  end

  assign rst_req_o = rst_q;
  assign irq_o     = irq_q;

  AST_RST_ONLY_IN_MODE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_req_o |-> $past(mode_i)); // R6
  AST_NO_IRQ_IN_RST_MODE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hit_i && mode_i && !irq_o) |=> !irq_o); // R6
  AST_IRQ_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_o && !ack_i) |=> irq_o); // R7
endmodule

// File: rtl/wdt_cmp_timer.sv
module wdt_cmp_timer
  import wdt_cmp_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             stop_i,
  input  logic             rst_mode_i,
  input  logic             wr_en_i,
  input  logic [REG_W-1:0] wr_data_i,
  input  logic             irq_ack_i,
  output logic             rst_req_o,
  output logic             irq_o
);
  cmp_t cmp;
  logic clr, hit;

  wdt_cmp_ctrl u_ctrl (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_en_i  (wr_en_i),
    .wr_data_i(wr_data_i),
    .cmp_o    (cmp),
    .clr_o    (clr)
  );

  wdt_cmp_counter u_cnt (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .tick_i(tick_i),
    .stop_i(stop_i),
    .clr_i (clr),
    .cmp_i (cmp),
    .hit_o (hit)
  );

  wdt_cmp_event u_evt (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .hit_i    (hit),
    .mode_i   (rst_mode_i),
    .ack_i    (irq_ack_i),
    .rst_req_o(rst_req_o),
    .irq_o    (irq_o)
  );
endmodule

// File: tb/wdt_cmp_timer_tb.sv
`timescale 1ns/1ps
module wdt_cmp_timer_tb;
  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic tick_i = 1'b0, stop_i = 1'b0, rst_mode_i = 1'b0;
  logic wr_en_i = 1'b0, irq_ack_i = 1'b0;
  logic [7:0] wr_data_i = '0;
  logic rst_req_o, irq_o;
  int checks = 0, failures = 0;
  bit done = 1'b0;

  always #4 clk_i = ~clk_i;

  wdt_cmp_timer u_dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .tick_i(tick_i), .stop_i(stop_i),
    .rst_mode_i(rst_mode_i), .wr_en_i(wr_en_i), .wr_data_i(wr_data_i),
    .irq_ack_i(irq_ack_i), .rst_req_o(rst_req_o), .irq_o(irq_o)
  );

  task automatic check(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      tick_i = 1'b1;
      @(negedge clk_i);
    end
    tick_i = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk_i);
  endtask

  // extra idle cycle lets the clear bit act before any tick
  task automatic wr(input logic [7:0] d);
    wr_en_i = 1'b1; wr_data_i = d;
    @(negedge clk_i);
    wr_en_i = 1'b0;
    @(negedge clk_i);
  endtask

  task automatic ack();
    irq_ack_i = 1'b1;
    @(negedge clk_i);
    irq_ack_i = 1'b0;
  endtask

  task automatic t_reset_default();
    check("R1 rst_req after reset", rst_req_o, 1'b0);
    check("R1 irq after reset", irq_o, 1'b0);
    ticks(127);
    check("R1 no expiry at tick 127", irq_o, 1'b0);
    ticks(1);
    check("R1 R5 expiry at tick 128", irq_o, 1'b1);
    idle(5);
    check("R7 irq sticky", irq_o, 1'b1);
    ack();
    check("R7 irq cleared by ack", irq_o, 1'b0);
  endtask

  task automatic t_clear();
    wr(8'h84);
    ticks(3);
    wr(8'h84);
    ticks(4);
    check("R3 no expiry after clear, tick 4", irq_o, 1'b0);
    ticks(1);
    check("R3 R5 expiry at tick 5 after clear", irq_o, 1'b1);
    ack();
  endtask

  task automatic t_cmp_no_clear();
    wr(8'h84);
    ticks(2);
    wr(8'h06);
    ticks(4);
    check("R2 count kept, no expiry at count 6", irq_o, 1'b0);
    ticks(1);
    check("R2 expiry on new compare 6", irq_o, 1'b1);
    ack();
  endtask

  task automatic t_idle();
    wr(8'h83);
    ticks(2);
    idle(20);
    ticks(1);
    check("R4 idle cycles do not count", irq_o, 1'b0);
    ticks(1);
    check("R4 expiry at 4th tick", irq_o, 1'b1);
    ack();
  endtask

  task automatic t_wrap();
    wr(8'h85);
    ticks(6);
    check("R8 first expiry", irq_o, 1'b1);
    ack();
    ticks(5);
    check("R8 no early second expiry", irq_o, 1'b0);
    ticks(1);
    check("R8 second expiry after 6 ticks", irq_o, 1'b1);
    ack();
  endtask

  task automatic t_stop();
    wr(8'h84);
    ticks(2);
    stop_i = 1'b1;
    ticks(10);
    check("R9 no expiry while stopped", irq_o, 1'b0);
    stop_i = 1'b0;
    ticks(2);
    check("R9 resumed, not yet expired", irq_o, 1'b0);
    ticks(1);
    check("R9 expiry continues held count", irq_o, 1'b1);
    ack();
  endtask

  task automatic t_reset_mode();
    rst_mode_i = 1'b1;
    wr(8'h83);
    ticks(3);
    check("R6 no reset request early", rst_req_o, 1'b0);
    ticks(1);
    check("R6 reset request on expiry", rst_req_o, 1'b1);
    check("R6 irq untouched in reset mode", irq_o, 1'b0);
    idle(1);
    check("R6 reset request one cycle", rst_req_o, 1'b0);
    rst_mode_i = 1'b0;
  endtask

  task automatic t_ack_collision();
    wr(8'h82);
    ticks(3);
    check("R7 expiry sets irq", irq_o, 1'b1);
    ticks(2);
    irq_ack_i = 1'b1; tick_i = 1'b1;
    @(negedge clk_i);
    irq_ack_i = 1'b0; tick_i = 1'b0;
    check("R7 expiry wins over ack", irq_o, 1'b1);
    ack();
    check("R7 ack clears", irq_o, 1'b0);
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    idle(3);
    rst_ni = 1'b1;
    idle(1);
    t_reset_default();
    t_clear();
    t_cmp_no_clear();
    t_idle();
    t_wrap();
    t_stop();
    t_reset_mode();
    t_ack_collision();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule